// File: doc/BRIEF.md
# Alternating Peak Finder

This block watches a stream of 8-bit decimated signal samples and pulls out the recent local minimum and maximum of the waveform. It alternates between two searches. While it looks for a minimum, it keeps the lowest sample seen so far. It commits that value as a minimum only after the signal has climbed back above it by a noise margin. The maximum search is the mirror image. Each commit ends one search and starts the other, so minima and maxima always come out in turn. Only recent extremes are kept, never all-time ones.

Each committed peak carries a tag. The tag is valid when a peak of the opposite kind was committed earlier, and invalid when the search simply began on a slope. The noise margin grows when the upstream amplifier sits at its highest gain. A clear pulse throws away all stored peaks and tags. The upstream logic raises that pulse on initialisation, on recalibration and on every gain change. A one-cycle strobe marks each found minimum (a rising edge) and each found maximum (a falling edge). Downstream output logic uses these strobes to switch its output during start-up.

Top module: `peak_track`

## Requirements
- R1: After reset, `lo_val` and `hi_val` are 0, `lo_ok` and `hi_ok` are 0, and no strobe is high.
- R2: The first accepted sample after reset or clear seeds both trackers. No peak is committed on that sample.
- R3: While a minimum is being searched, a lower sample replaces the tracked value and a higher one leaves it alone. When a sample is at least the tracked value plus the margin (s >= trk + K), the tracked value is written to `lo_val` and `lo_hit` pulses for one cycle. Both happen at the clock edge after the sample is taken.
- R4: While a maximum is being searched, the same rules apply mirrored. A sample with s + K <= trk commits the tracked value to `hi_val` and pulses `hi_hit`.
- R5: The margin K is 0x30 when `gain_top` is low and 0x48 when `gain_top` is high. `gain_top` is sampled together with each sample.
- R6: Commits alternate strictly. A minimum commit starts a maximum search, and a maximum commit starts a minimum search. The new search begins from the committing sample.
- R7: Before the first commit after a clear, both directions are tracked. Whichever direction first reaches the margin decides which kind of peak comes first.
- R8: A committed peak is flagged valid (`lo_ok` or `hi_ok` = 1) only if a peak of the opposite kind was committed since the last clear. Otherwise it is flagged 0.
- R9: A `clr` pulse sets both values and both flags to 0, drops any strobe and restarts at the seeding step. A sample presented in the same cycle as `clr` is discarded.
- R10: A sample with `smp_vld` low has no effect on any tracker, register or strobe.
- R11: Margin comparisons use one extra bit, so a tracked value near 0xFF plus the margin never wraps into a false commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample qualifier |
| smp | input | 8 | Decimated sample value |
| gain_top | input | 1 | High when the amplifier is at its maximum gain step |
| clr | input | 1 | Discards all peak state (init, recalibration, gain change) |
| lo_val | output | 8 | Last committed minimum |
| lo_ok | output | 1 | Validity tag of `lo_val` |
| lo_hit | output | 1 | One-cycle strobe: minimum found (rising edge) |
| hi_val | output | 8 | Last committed maximum |
| hi_ok | output | 1 | Validity tag of `hi_val` |
| hi_hit | output | 1 | One-cycle strobe: maximum found (falling edge) |

## Verification
The bench applies samples exactly one below and exactly at the margin on both sides. A design using a strict comparison, or off by one, would then commit a peak a sample late or too early. It seeds a tracker at 0xE0 and then feeds 0xFF, where an 8-bit sum wraps and a narrow adder would report a false minimum. It drops the signal by 0x30 with `gain_top` high, and a block that ignores the gain flag would commit that maximum early. It also repeats the first peak after a clear, after a direction-first fall and after idle samples, to catch stale validity tags, samples that leak through while `smp_vld` is low, and a clear that loses to a same-cycle sample.

// File: rtl/pk_pkg.sv
package pk_pkg;

  // Search phase of the peak finder
  typedef enum logic [1:0] {
    PH_SEED = 2'd0,  // waiting for the first sample after clear
    PH_BOTH = 2'd1,  // direction not yet decided, both trackers live
    PH_LO   = 2'd2,  // hunting a minimum
    PH_HI   = 2'd3   // hunting a maximum
  } pk_phase_e;

endpackage

// File: rtl/pk_margin.sv
module pk_margin #(
  parameter int             DW      = 8,
  parameter logic [DW-1:0]  NZ_BASE = 8'h30,
  parameter logic [DW-1:0]  NZ_TOP  = 8'h48
) (
  input  logic          gain_top,
  output logic [DW:0]   k
);

  // Margin widened by one bit so later sums stay exact
  always_comb begin
    if (gain_top) k = {1'b0, NZ_TOP};
    else          k = {1'b0, NZ_BASE};
  end

endmodule

// File: rtl/pk_extreme.sv
module pk_extreme #(
  parameter int DW     = 8,
  parameter bit IS_MAX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,   // seed tracker with s
  input  logic          upd,    // fold s into the running extreme
  input  logic [DW-1:0] s,
  input  logic [DW:0]   k,
  output logic [DW-1:0] val,
  output logic          away    // s has left val by at least k
);

  logic [DW-1:0] val_q;
  logic [DW-1:0] val_d;
  logic          better;
  logic [DW:0]   s_w;
  logic [DW:0]   v_w;

  assign s_w = {1'b0, s};
  assign v_w = {1'b0, val_q};

  generate
    if (IS_MAX) begin : g_max
      always_comb begin
        better = (s > val_q);
        away   = ((s_w + k) <= v_w);
      end
    end else begin : g_min
      always_comb begin
        better = (s < val_q);
        away   = (s_w >= (v_w + k));
      end
    end
  endgenerate

  always_comb begin
    val_d = val_q;
    if (load)                val_d = s;
    else if (upd && better)  val_d = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val = val_q;

endmodule

// File: rtl/pk_seq.sv
module pk_seq
  import pk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp,
  input  logic          clr,
  input  logic [DW-1:0] lo_trk,
  input  logic          lo_away,
  input  logic [DW-1:0] hi_trk,
  input  logic          hi_away,
  output logic          lo_load,
  output logic          lo_upd,
  output logic          hi_load,
  output logic          hi_upd,
  output logic [DW-1:0] lo_val,
  output logic          lo_ok,
  output logic          lo_hit,
  output logic [DW-1:0] hi_val,
  output logic          hi_ok,
  output logic          hi_hit
);

  pk_phase_e     ph_q, ph_d;
  logic [DW-1:0] lo_val_q, lo_val_d, hi_val_q, hi_val_d;
  logic          lo_ok_q, lo_ok_d, hi_ok_q, hi_ok_d;
  logic          have_lo_q, have_lo_d, have_hi_q, have_hi_d;
  logic          lo_hit_q, lo_hit_d, hi_hit_q, hi_hit_d;
  logic          take;
  logic          cm_lo, cm_hi;
  logic          unused_smp;

  assign take       = smp_vld && !clr;
  assign unused_smp = ^smp;

  // Phase decision and tracker controls
  always_comb begin
    ph_d    = ph_q;
    lo_load = 1'b0;
    lo_upd  = 1'b0;
    hi_load = 1'b0;
    hi_upd  = 1'b0;
    cm_lo   = 1'b0;
    cm_hi   = 1'b0;
    if (take) begin
      unique case (ph_q)
        PH_SEED: begin
          lo_load = 1'b1;
          hi_load = 1'b1;
          ph_d    = PH_BOTH;
        end
        PH_BOTH: begin
          if (lo_away) begin
            cm_lo   = 1'b1;
            hi_load = 1'b1;
            ph_d    = PH_HI;
          end else if (hi_away) begin
            cm_hi   = 1'b1;
            lo_load = 1'b1;
            ph_d    = PH_LO;
          end else begin
            lo_upd  = 1'b1;
            hi_upd  = 1'b1;
          end
        end
        PH_LO: begin
          if (lo_away) begin
            cm_lo   = 1'b1;
            hi_load = 1'b1;
            ph_d    = PH_HI;
          end else begin
            lo_upd  = 1'b1;
          end
        end
        PH_HI: begin
          if (hi_away) begin
            cm_hi   = 1'b1;
            lo_load = 1'b1;
            ph_d    = PH_LO;
          end else begin
            hi_upd  = 1'b1;
          end
        end
        default: ph_d = PH_SEED;
      endcase
    end
    if (clr) ph_d = PH_SEED;
  end

  // Result registers, validity tags and strobes
  always_comb begin
    lo_val_d  = lo_val_q;
    hi_val_d  = hi_val_q;
    lo_ok_d   = lo_ok_q;
    hi_ok_d   = hi_ok_q;
    have_lo_d = have_lo_q;
    have_hi_d = have_hi_q;
    lo_hit_d  = 1'b0;
    hi_hit_d  = 1'b0;
    if (clr) begin
      lo_val_d  = '0;
      hi_val_d  = '0;
      lo_ok_d   = 1'b0;
      hi_ok_d   = 1'b0;
      have_lo_d = 1'b0;
      have_hi_d = 1'b0;
    end else if (cm_lo) begin
      lo_val_d  = lo_trk;
      lo_ok_d   = have_hi_q;
      have_lo_d = 1'b1;
      lo_hit_d  = 1'b1;
    end else if (cm_hi) begin
      hi_val_d  = hi_trk;
      hi_ok_d   = have_lo_q;
      have_hi_d = 1'b1;
      hi_hit_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_SEED;
      lo_val_q  <= '0;
      hi_val_q  <= '0;
      lo_ok_q   <= 1'b0;
      hi_ok_q   <= 1'b0;
      have_lo_q <= 1'b0;
      have_hi_q <= 1'b0;
      lo_hit_q  <= 1'b0;
      hi_hit_q  <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      lo_val_q  <= lo_val_d;
      hi_val_q  <= hi_val_d;
      lo_ok_q   <= lo_ok_d;
      hi_ok_q   <= hi_ok_d;
      have_lo_q <= have_lo_d;
      have_hi_q <= have_hi_d;
      lo_hit_q  <= lo_hit_d;
      hi_hit_q  <= hi_hit_d;
    end
  end

  assign lo_val = lo_val_q;
  assign hi_val = hi_val_q;
  assign lo_ok  = lo_ok_q;
  assign hi_ok  = hi_ok_q;
  assign lo_hit = lo_hit_q;
  assign hi_hit = hi_hit_q;

endmodule

// File: rtl/peak_track.sv
module peak_track #(
  parameter int             DW      = 8,
  parameter logic [DW-1:0]  NZ_BASE = 8'h30,
  parameter logic [DW-1:0]  NZ_TOP  = 8'h48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp,
  input  logic          gain_top,
  input  logic          clr,
  output logic [DW-1:0] lo_val,
  output logic          lo_ok,
  output logic          lo_hit,
  output logic [DW-1:0] hi_val,
  output logic          hi_ok,
  output logic          hi_hit
);

  logic [DW:0]   k;
  logic [DW-1:0] lo_trk, hi_trk;
  logic          lo_away, hi_away;
  logic          lo_load, lo_upd, hi_load, hi_upd;

  pk_margin #(.DW(DW), .NZ_BASE(NZ_BASE), .NZ_TOP(NZ_TOP)) margin_i (
    .gain_top (gain_top),
    .k        (k)
  );

  pk_extreme #(.DW(DW), .IS_MAX(1'b0)) trk_lo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (lo_load),
    .upd   (lo_upd),
    .s     (smp),
    .k     (k),
    .val   (lo_trk),
    .away  (lo_away)
  );

  pk_extreme #(.DW(DW), .IS_MAX(1'b1)) trk_hi_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hi_load),
    .upd   (hi_upd),
    .s     (smp),
    .k     (k),
    .val   (hi_trk),
    .away  (hi_away)
  );

  pk_seq #(.DW(DW)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .smp     (smp),
    .clr     (clr),
    .lo_trk  (lo_trk),
    .lo_away (lo_away),
    .hi_trk  (hi_trk),
    .hi_away (hi_away),
    .lo_load (lo_load),
    .lo_upd  (lo_upd),
    .hi_load (hi_load),
    .hi_upd  (hi_upd),
    .lo_val  (lo_val),
    .lo_ok   (lo_ok),
    .lo_hit  (lo_hit),
    .hi_val  (hi_val),
    .hi_ok   (hi_ok),
    .hi_hit  (hi_hit)
  );

endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
  parameter int             DW      = 8,
  parameter logic [DW-1:0]  NZ_BASE = 8'h30,
  parameter logic [DW-1:0]  NZ_TOP  = 8'h48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [DW-1:0] smp,
  input logic          gain_top,
  input logic          clr,
  input logic [DW-1:0] lo_val,
  input logic          lo_ok,
  input logic          lo_hit,
  input logic [DW-1:0] hi_val,
  input logic          hi_ok,
  input logic          hi_hit
);

  logic [DW-1:0] smp_q;
  logic [DW:0]   k_q;
  logic          any_q, last_hi_q, seen_lo_q, seen_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q     <= '0;
      k_q       <= '0;
      any_q     <= 1'b0;
      last_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
      seen_hi_q <= 1'b0;
    end else begin
      smp_q <= smp;
      k_q   <= gain_top ? {1'b0, NZ_TOP} : {1'b0, NZ_BASE};
      if (clr) begin
        any_q     <= 1'b0;
        last_hi_q <= 1'b0;
        seen_lo_q <= 1'b0;
        seen_hi_q <= 1'b0;
      end else if (lo_hit) begin
        any_q     <= 1'b1;
        last_hi_q <= 1'b0;
        seen_lo_q <= 1'b1;
      end else if (hi_hit) begin
        any_q     <= 1'b1;
        last_hi_q <= 1'b1;
        seen_hi_q <= 1'b1;
      end
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_hit && hi_hit));

  // R6
  alt_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |-> !(any_q && !last_hi_q));

  // R6
  alt_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_hit |-> !(any_q && last_hi_q));

  // R8
  lo_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |-> (lo_ok == seen_hi_q));

  // R8
  hi_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_hit |-> (hi_ok == seen_lo_q));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !(lo_hit || hi_hit));

  // R9
  clr_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lo_val == '0 && hi_val == '0 && !lo_ok && !hi_ok && !lo_hit && !hi_hit));

  // R5
  lo_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |-> ({1'b0, smp_q} >= ({1'b0, lo_val} + k_q)));

  // R11
  hi_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_hit |-> (({1'b0, smp_q} + k_q) <= {1'b0, hi_val}));

  // R3
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_hit && !$past(clr)) |-> $stable(lo_val));

  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_hit && !$past(clr)) |-> $stable(hi_val));

endmodule

bind peak_track pk_checker #(.DW(DW), .NZ_BASE(NZ_BASE), .NZ_TOP(NZ_TOP)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_vld  (smp_vld),
  .smp      (smp),
  .gain_top (gain_top),
  .clr      (clr),
  .lo_val   (lo_val),
  .lo_ok    (lo_ok),
  .lo_hit   (lo_hit),
  .hi_val   (hi_val),
  .hi_ok    (hi_ok),
  .hi_hit   (hi_hit)
);

// File: tb/peak_track_tb_top.sv
module peak_track_tb_top;

  localparam int PER = 10;

  typedef struct packed {
    logic       hi;
    logic [7:0] v;
    logic       ok;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_vld;
  logic [7:0] smp;
  logic       gain_top;
  logic       clr;
  logic [7:0] lo_val, hi_val;
  logic       lo_ok, hi_ok, lo_hit, hi_hit;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  exp_t  q_exp[$];
  string q_tag[$];

  // reference state built from the requirements
  int m_ph = 0;  // 0 seed, 1 both, 2 min search, 3 max search
  int m_lo = 0;
  int m_hi = 0;
  bit m_have_lo = 1'b0;
  bit m_have_hi = 1'b0;

  always #(PER/2) clk = ~clk;

  peak_track dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp      (smp),
    .gain_top (gain_top),
    .clr      (clr),
    .lo_val   (lo_val),
    .lo_ok    (lo_ok),
    .lo_hit   (lo_hit),
    .hi_val   (hi_val),
    .hi_ok    (hi_ok),
    .hi_hit   (hi_hit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_lo();
    exp_t e;
    e.hi = 1'b0; e.v = m_lo[7:0]; e.ok = m_have_hi;
    q_exp.push_back(e); q_tag.push_back("R3 R8");
    m_have_lo = 1'b1;
  endtask

  task automatic push_hi();
    exp_t e;
    e.hi = 1'b1; e.v = m_hi[7:0]; e.ok = m_have_lo;
    q_exp.push_back(e); q_tag.push_back("R4 R8");
    m_have_hi = 1'b1;
  endtask

  task automatic model(input int s, input bit gt);
    int k;
    k = gt ? 'h48 : 'h30;
    case (m_ph)
      0: begin m_lo = s; m_hi = s; m_ph = 1; end
      1: begin
        if (s >= m_lo + k)      begin push_lo(); m_hi = s; m_ph = 3; end
        else if (s + k <= m_hi) begin push_hi(); m_lo = s; m_ph = 2; end
        else begin
          if (s < m_lo) m_lo = s;
          if (s > m_hi) m_hi = s;
        end
      end
      2: begin
        if (s >= m_lo + k) begin push_lo(); m_hi = s; m_ph = 3; end
        else if (s < m_lo) m_lo = s;
      end
      default: begin
        if (s + k <= m_hi) begin push_hi(); m_lo = s; m_ph = 2; end
        else if (s > m_hi) m_hi = s;
      end
    endcase
  endtask

  // driver: applies one cycle of stimulus and records what must follow
  task automatic put(input int s, input bit v, input bit gt, input bit c);
    @(posedge clk); #(PER/4);
    smp = s[7:0]; smp_vld = v; gain_top = gt; clr = c;
    if (c) begin
      m_ph = 0; m_have_lo = 1'b0; m_have_hi = 1'b0;
    end else if (v) begin
      model(s, gt);
    end
  endtask

  // let the last sample land, then stand at the following negedge
  task automatic settle();
    @(posedge clk); #(PER/4);
    smp_vld = 1'b0; clr = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops one expected commit per observed strobe
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (lo_hit || hi_hit)) begin
      n_chk++;
      if (lo_hit && hi_hit) begin
        n_fail++;
        $display("FAIL R6: both strobes high, expected one");
      end else if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL R6: strobe lo=%0b hi=%0b, expected none", lo_hit, hi_hit);
      end else begin
        exp_t  e;
        string t;
        logic [7:0] av;
        logic       aok;
        e  = q_exp.pop_front();
        t  = q_tag.pop_front();
        av  = hi_hit ? hi_val : lo_val;
        aok = hi_hit ? hi_ok  : lo_ok;
        if (e.hi != hi_hit || e.v != av || e.ok != aok) begin
          n_fail++;
          $display("FAIL %s: actual hi=%0b val=%0h ok=%0b expected hi=%0b val=%0h ok=%0b",
                   t, hi_hit, av, aok, e.hi, e.v, e.ok);
        end
      end
    end
  end

  initial begin
    #(PER * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; smp = '0; gain_top = 1'b0; clr = 1'b0;
    repeat (3) @(posedge clk);
    #(PER/4); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lo_val", lo_val, 0);
    chk("R1 hi_val", hi_val, 0);
    chk("R1 flags",  {lo_ok, hi_ok, lo_hit, hi_hit}, 0);

    // R2 seed, R3 one short of the margin
    put('h40, 1, 0, 0); put('h50, 1, 0, 0); put('h6F, 1, 0, 0);
    settle();
    chk("R2 no commit on seed/near", lo_val, 0);
    // R3 R7 rising first: min 0x40 invalid
    put('h70, 1, 0, 0);
    settle();
    chk("R3 lo_val", lo_val, 'h40);
    chk("R8 lo_ok invalid", lo_ok, 0);
    // R4 R6 max search starts at 0x70
    put('hA0, 1, 0, 0); put('h71, 1, 0, 0);
    settle();
    chk("R4 short drop", hi_val, 0);
    put('h70, 1, 0, 0);
    settle();
    chk("R4 hi_val", hi_val, 'hA0);
    chk("R8 hi_ok valid", hi_ok, 1);
    // R6 minimum from 0x70 down to 0x20
    put('h20, 1, 0, 0); put('h4F, 1, 0, 0); put('h50, 1, 0, 0);
    settle();
    chk("R6 lo_val", lo_val, 'h20);
    chk("R8 lo_ok valid", lo_ok, 1);
    // R5 raised margin
    put('hC0, 1, 1, 0); put('h90, 1, 1, 0);
    settle();
    chk("R5 drop 0x30 at top gain", hi_val, 'hA0);
    put('h78, 1, 1, 0);
    settle();
    chk("R5 hi_val", hi_val, 'hC0);
    // R10 idle samples ignored
    put('h00, 0, 0, 0); put('hFF, 0, 0, 0);
    settle();
    chk("R10 lo_val held", lo_val, 'h20);
    chk("R10 hi_val held", hi_val, 'hC0);
    put('hA8, 1, 0, 0);
    settle();
    chk("R10 tracker untouched", lo_val, 'h78);
    // R9 clear beats a same-cycle sample
    put('h10, 1, 0, 1);
    settle();
    chk("R9 values", {lo_val, hi_val}, 0);
    chk("R9 flags", {lo_ok, hi_ok}, 0);
    // R11 no wrap near full scale
    put('hE0, 1, 0, 0); put('hFF, 1, 0, 0);
    settle();
    chk("R11 no false min", lo_val, 0);
    // R7 falling first: max 0xFF invalid
    put('h10, 1, 0, 0);
    settle();
    chk("R7 hi_val", hi_val, 'hFF);
    chk("R8 hi_ok invalid", hi_ok, 0);

    // random walks, one clear per segment
    for (int seg = 0; seg < 4; seg++) begin
      int  x;
      bit  up;
      bit  gt;
      gt = seg[0];
      x  = 128;
      up = 1'b1;
      put(0, 0, gt, 1);
      for (int i = 0; i < 500; i++) begin
        int st;
        st = int'($urandom_range(0, 24));
        x  = up ? x + st : x - st;
        if (x > 255) begin x = 255; up = 1'b0; end
        if (x < 0)   begin x = 0;   up = 1'b1; end
        if ($urandom_range(0, 15) == 0) up = ~up;
        put(x, ($urandom_range(0, 7) != 0), gt, 0);
      end
    end
    settle();
    repeat (3) @(negedge clk);
    // R3 R4 every expected commit was observed
    chk("R3 R4 pending commits", q_exp.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule